// File: doc/BRIEF.md
# SD Command Line Engine

This block drives the single-bit command line of an SD or eMMC card interface. A 16-bit command word and a 32-bit argument are offered on a valid/ready handshake. The engine then shifts out a 48-bit command frame, one bit per clock, most significant bit first. The frame carries its own CRC7 checksum.

Once the frame has been sent, the engine listens on the same line for the card's reply. It captures the reply in the layout selected by a 3-bit response-type code in the command word. A short reply keeps its 32-bit payload. A long reply keeps its 120 content bits, split into four 32-bit words. The engine checks the reply for the end bit, the echoed index and the CRC7 where that reply class calls for it. If no start bit arrives in time, it raises a timeout.

The handshake has simple back-pressure rules. `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. A command held on the inputs while `cmd_ready` is low waits, and it is neither dropped nor started. Status is reported as two plain 16-bit vectors.

Top module: `sdc_cmd_engine`

## Requirements
- R1: The clock edge after acceptance starts the frame on `cmd_o`, and `cmd_oe` stays high for exactly 48 cycles. The frame is sent MSB first and is made of: a 0 start bit, a 1 direction bit, the index from command word bits 5:0, the 32-bit argument, seven CRC bits and a 1 end bit.
- R2: The seven CRC bits are the CRC7 (polynomial x^7+x^3+1, register initialised to zero) of the 40 bits that precede them. For example, index 0 with argument 0 gives the frame 0x400000000095.
- R3: `cmd_ready` is high only when idle. Status-2 bit 14 (busy) is set from the cycle after acceptance until completion. A command offered while busy is not started.
- R4: Response codes 1, 2 and 3 (command word bits 10:8) mean no reply. Status-1 bit 0 (done) is set and busy clears on the clock edge after the end bit.
- R5: Codes 0, 4, 5 and 7 take a 48-bit reply. Reply bits 39:8 go to `rsp0`, and `rsp1` to `rsp3` are cleared.
- R6: Code 6 takes a 136-bit reply. Reply bits 39:8, 71:40 and 103:72 go to `rsp0`, `rsp1` and `rsp2`. Reply bits 127:104 go to `rsp3` bits 23:0, and `rsp3` bits 31:24 read zero.
- R7: The reply start bit must be seen within 64 samples after the end bit. Arriving in the 64th sample is still in time. Otherwise status-2 bit 6 is set, done stays clear, busy clears and `rsp0` to `rsp3` are left unchanged.
- R8: A CRC7 mismatch sets status-2 bit 1. Codes 0, 4 and 5 check the reply's first 40 bits against reply bits 7:1. Code 6 checks reply bits 127:8 against bits 7:1. Code 7 is never checked.
- R9: A reply whose last bit is 0 sets status-2 bit 2.
- R10: For codes 0, 4 and 5, reply bits 45:40 that differ from the sent index set status-2 bit 0. Codes 6 and 7 ignore that field.
- R11: For code 5, done is withheld and busy stays set until `dat0_i` is high. The engine completes on the edge after it sees `dat0_i` high.
- R12: Acceptance clears done and the error bits. `xfer_ctl` takes command word bits 14:11 at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command may be taken |
| cmd_word | input | 16 | Index, response code and transfer flags |
| cmd_arg | input | 32 | Command argument |
| cmd_o | output | 1 | Command line output |
| cmd_oe | output | 1 | Command line output enable |
| cmd_i | input | 1 | Command line input from card |
| dat0_i | input | 1 | Data line 0, low while card is busy |
| rsp0 | output | 32 | Reply bits 39:8 |
| rsp1 | output | 32 | Reply bits 71:40 (long only) |
| rsp2 | output | 32 | Reply bits 103:72 (long only) |
| rsp3 | output | 32 | Reply bits 127:104 in 23:0 (long only) |
| stat1 | output | 16 | Bit 0 done |
| stat2 | output | 16 | Bit 14 busy, 6 timeout, 2 end, 1 CRC, 0 index |
| xfer_ctl | output | 4 | Latched command word bits 14:11 |

## Verification
The bench sweeps all eight response codes across several indices, arguments and reply delays. This shows that each code selects the correct reply length, storage layout and set of checks. Frames are compared with a CRC computed in the bench and with three known command frames. The delay of 63 against 64 idle samples marks the timeout boundary. Corrupted CRC, end bit and index are injected under each reply class to show which classes check what. A busy-line hold combined with a pending command shows that completion is withheld and that back-pressure works.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;

  localparam logic [2:0] RT_AUTO  = 3'd0;
  localparam logic [2:0] RT_SHORT = 3'd4;
  localparam logic [2:0] RT_BUSY  = 3'd5;
  localparam logic [2:0] RT_LONG  = 3'd6;
  localparam logic [2:0] RT_NOCRC = 3'd7;

  typedef enum logic [1:0] {E_IDLE, E_SEND, E_RESP, E_HOLD} eng_state_t;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_word(input logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx
  import sdc_pkg::*;
#(
  parameter int FRAME = FRAME_BITS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic        line,
  output logic        oe,
  output logic        last
);
  localparam int CW = $clog2(FRAME);
  localparam logic [CW-1:0] LASTC = CW'(FRAME - 1);

  logic [FRAME-1:0] sh;
  logic [CW-1:0]    cnt;
  logic             act;
  logic [39:0]      head;

  assign head = {2'b01, idx, arg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
      act <= 1'b0;
    end else if (load) begin
      sh  <= {head, crc7_word(head), 1'b1};
      cnt <= '0;
      act <= 1'b1;
    end else if (act) begin
      sh  <= {sh[FRAME-2:0], 1'b1};
      cnt <= cnt + 1'b1;
      if (cnt == LASTC) act <= 1'b0;
    end
  end

  assign line = act ? sh[FRAME-1] : 1'b1;
  assign oe   = act;
  assign last = act && (cnt == LASTC);

  // R1: the line sits high whenever it is not driven
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> line);
endmodule

// File: rtl/sdc_rsp_rx.sv
module sdc_rsp_rx
  import sdc_pkg::*;
#(
  parameter int TMO   = 64,
  parameter int SHORT = FRAME_BITS,
  parameter int LONG  = LONG_BITS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        long_mode,
  input  logic        chk_crc,
  input  logic        chk_idx,
  input  logic [5:0]  exp_idx,
  input  logic        line,
  output logic        fin,
  output logic        tmo,
  output logic        crc_err,
  output logic        end_err,
  output logic        idx_err,
  output logic [31:0] w0,
  output logic [31:0] w1,
  output logic [31:0] w2,
  output logic [31:0] w3
);
  localparam int CW = $clog2(LONG + 1);
  localparam int TW = $clog2(TMO);
  localparam logic [CW-1:0] S_END  = CW'(SHORT - 1);
  localparam logic [CW-1:0] L_END  = CW'(LONG - 1);
  localparam logic [CW-1:0] S_CRCE = CW'(SHORT - 9);
  localparam logic [CW-1:0] L_CRCB = CW'(LONG - 128);
  localparam logic [CW-1:0] L_CRCE = CW'(LONG - 9);
  localparam logic [TW-1:0] T_LAST = TW'(TMO - 1);

  typedef enum logic [1:0] {R_OFF, R_WAIT, R_RECV} rx_state_t;

  rx_state_t       st;
  logic [LONG-1:0] sh, nx;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   wcnt;
  logic [6:0]      crc;
  logic            last, in_crc;

  assign nx     = {sh[LONG-2:0], line};
  assign last   = (st == R_RECV) && (cnt == (long_mode ? L_END : S_END));
  assign in_crc = long_mode ? (cnt >= L_CRCB && cnt <= L_CRCE) : (cnt <= S_CRCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_OFF; sh <= '0; cnt <= '0; wcnt <= '0; crc <= '0;
      w0 <= '0; w1 <= '0; w2 <= '0; w3 <= '0;
    end else if (start) begin
      st <= R_WAIT; sh <= '0; cnt <= '0; wcnt <= '0; crc <= '0;
    end else begin
      case (st)
        R_WAIT: begin
          if (!line) begin
            st  <= R_RECV;
            sh  <= nx;
            cnt <= CW'(1);
          end else if (wcnt == T_LAST) begin
            st <= R_OFF;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        R_RECV: begin
          sh  <= nx;
          cnt <= cnt + 1'b1;
          if (in_crc) crc <= crc7_step(crc, line);
          if (last) begin
            st <= R_OFF;
            w0 <= nx[39:8];
            w1 <= long_mode ? nx[71:40] : '0;
            w2 <= long_mode ? nx[103:72] : '0;
            w3 <= long_mode ? {8'h00, nx[127:104]} : '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign tmo     = (st == R_WAIT) && line && (wcnt == T_LAST);
  assign fin     = last || tmo;
  assign crc_err = last && chk_crc && (crc != nx[7:1]);
  assign end_err = last && !line;
  assign idx_err = last && chk_idx && !long_mode && (nx[45:40] != exp_idx);

  // R7: a reply is never both timed out and received
  p_tmo_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> !(crc_err || end_err || idx_err));
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [15:0] cmd_word,
  input  logic [31:0] cmd_arg,
  output logic        cmd_o,
  output logic        cmd_oe,
  input  logic        cmd_i,
  input  logic        dat0_i,
  output logic [31:0] rsp0,
  output logic [31:0] rsp1,
  output logic [31:0] rsp2,
  output logic [31:0] rsp3,
  output logic [15:0] stat1,
  output logic [15:0] stat2,
  output logic [3:0]  xfer_ctl
);
  eng_state_t state;
  logic [2:0] rtype;
  logic [5:0] idx_q;
  logic done_q, tmo_q, crc_q, end_q, idx_q_err;
  logic accept, tx_last, has_rsp, chk_crc, chk_idx, long_m;
  logic rx_start, rx_fin, rx_tmo, rx_crc, rx_end, rx_idx;
  logic unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd_word[15], cmd_word[7:6]};
  assign cmd_ready = (state == E_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    has_rsp = rtype inside {RT_AUTO, RT_SHORT, RT_BUSY, RT_LONG, RT_NOCRC};
    chk_crc = rtype inside {RT_AUTO, RT_SHORT, RT_BUSY, RT_LONG};
    chk_idx = rtype inside {RT_AUTO, RT_SHORT, RT_BUSY};
    long_m  = (rtype == RT_LONG);
  end

  assign rx_start = (state == E_SEND) && tx_last && has_rsp;

  sdc_cmd_tx #(.FRAME(FRAME_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .idx(cmd_word[5:0]), .arg(cmd_arg),
    .line(cmd_o), .oe(cmd_oe), .last(tx_last)
  );

  sdc_rsp_rx #(.TMO(TMO_CYCLES), .SHORT(FRAME_BITS), .LONG(LONG_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .long_mode(long_m),
    .chk_crc(chk_crc), .chk_idx(chk_idx), .exp_idx(idx_q), .line(cmd_i),
    .fin(rx_fin), .tmo(rx_tmo), .crc_err(rx_crc), .end_err(rx_end), .idx_err(rx_idx),
    .w0(rsp0), .w1(rsp1), .w2(rsp2), .w3(rsp3)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= E_IDLE; rtype <= '0; idx_q <= '0; xfer_ctl <= '0;
      done_q <= 1'b0; tmo_q <= 1'b0; crc_q <= 1'b0; end_q <= 1'b0; idx_q_err <= 1'b0;
    end else begin
      case (state)
        E_IDLE: if (accept) begin
          state <= E_SEND;
          rtype <= cmd_word[10:8];
          idx_q <= cmd_word[5:0];
          xfer_ctl <= cmd_word[14:11];
          done_q <= 1'b0; tmo_q <= 1'b0; crc_q <= 1'b0; end_q <= 1'b0; idx_q_err <= 1'b0;
        end
        E_SEND: if (tx_last) begin
          if (has_rsp) state <= E_RESP;
          else begin state <= E_IDLE; done_q <= 1'b1; end
        end
        E_RESP: if (rx_fin) begin
          tmo_q <= rx_tmo; crc_q <= rx_crc; end_q <= rx_end; idx_q_err <= rx_idx;
          if (rx_tmo) state <= E_IDLE;
          else if (rtype == RT_BUSY) state <= E_HOLD;
          else begin state <= E_IDLE; done_q <= 1'b1; end
        end
        default: if (dat0_i) begin state <= E_IDLE; done_q <= 1'b1; end
      endcase
    end
  end

  assign stat1 = {15'b0, done_q};
  assign stat2 = {1'b0, (state != E_IDLE), 7'b0, tmo_q, 3'b0, end_q, crc_q, idx_q_err};

  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_o);
  p_busy_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> stat2[14]);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat1[0]) |-> (!stat2[14] && !cmd_oe));
  p_silent_listen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == E_RESP) |-> !cmd_oe);
  p_tmo_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat2[6]) |-> !stat1[0]);
  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == E_HOLD && !dat0_i) |=> (stat2[14] && !stat1[0]));
endmodule

// File: tb/sdc_cmd_engine_bench.sv
module sdc_cmd_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_i = 1'b1, dat0_i = 1'b1;
  logic [15:0] cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic cmd_ready, cmd_o, cmd_oe;
  logic [31:0] rsp0, rsp1, rsp2, rsp3;
  logic [15:0] stat1, stat2;
  logic [3:0] xfer_ctl;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdc_cmd_engine u_sdc_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_arg(cmd_arg), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
    .cmd_i(cmd_i), .dat0_i(dat0_i), .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2),
    .rsp3(rsp3), .stat1(stat1), .stat2(stat2), .xfer_ctl(xfer_ctl)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [119:0] v, input int n);
    logic [6:0] r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = r[6] ^ v[i];
      r = {r[5:0], 1'b0};
      if (fb) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  function automatic logic [47:0] mkframe(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, bcrc({80'b0, h}, 40), 1'b1};
  endfunction

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] code,
                       output logic [47:0] fr);
    @(negedge clk);
    cmd_word = {1'b0, arg[3:0], code, 2'b00, idx};
    cmd_arg = arg;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3 busy after accept", {cmd_ready, stat2[14]}, 2'b01);
    chk("R12 flags cleared", {stat1[0], stat2[6], stat2[2:0]}, 0);
    chk("R12 xfer_ctl", xfer_ctl, arg[3:0]);
    for (int i = 0; i < 48; i++) begin
      if (!cmd_oe) chk("R1 oe during frame", 0, 1);
      fr[47 - i] = cmd_o;
      if (i < 47) @(negedge clk);
    end
  endtask

  task automatic card(input logic [135:0] b, input int len, input int dly);
    @(negedge clk);
    repeat (dly) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_i = b[i];
      @(negedge clk);
    end
    cmd_i = 1'b1;
  endtask

  task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] code,
                        input bit bad_crc, input bit bad_end, input bit bad_idx, input int dly);
    logic [47:0] fr;
    logic [31:0] pl;
    logic [119:0] cont;
    logic [39:0] h;
    logic [135:0] rb;
    logic [5:0] fi;
    bit sh_chk;
    issue(idx, arg, code, fr);
    chk("R1 R2 frame", fr, mkframe(idx, arg));
    if (code inside {3'd1, 3'd2, 3'd3}) begin
      @(negedge clk);
      chk("R4 no-reply done", {stat1[0], stat2[14], cmd_oe}, 3'b100);
      return;
    end
    pl = arg ^ 32'h5A5A0F0F;
    cont = {arg[23:0] ^ 24'hC3A5F0, ~arg, arg * 3, arg ^ 32'h12345678};
    sh_chk = code inside {3'd0, 3'd4, 3'd5};
    if (code == 3'd6) begin
      rb = {2'b00, 6'h3f, cont, bcrc(cont, 120) ^ {6'b0, bad_crc}, !bad_end};
      card(rb, 136, dly);
    end else begin
      fi = (code == 3'd7) ? 6'h3f : (idx ^ {5'b0, bad_idx});
      h = {2'b00, fi, pl};
      rb = {88'b0, h, ((code == 3'd7) ? 7'h7f : bcrc({80'b0, h}, 40)) ^ {6'b0, bad_crc}, !bad_end};
      card(rb, 48, dly);
    end
    if (code == 3'd5) @(negedge clk);
    chk("R5 R6 done", {stat1[0], stat2[14], stat2[6]}, 3'b100);
    if (code == 3'd6) begin
      chk("R6 rsp0", rsp0, cont[31:0]);
      chk("R6 rsp1", rsp1, cont[63:32]);
      chk("R6 rsp2", rsp2, cont[95:64]);
      chk("R6 rsp3", rsp3, {8'h00, cont[119:96]});
    end else begin
      chk("R5 rsp0", rsp0, pl);
      chk("R5 rsp1-3 zero", {rsp1, rsp2, rsp3} == 96'b0, 1);
    end
    chk("R8 crc flag", stat2[1], bad_crc && code != 3'd7);
    chk("R9 end flag", stat2[2], bad_end);
    chk("R10 index flag", stat2[0], bad_idx && sh_chk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] fr;
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset state", {cmd_ready, cmd_oe, cmd_o, stat1, stat2, rsp0}, {3'b101, 32'b0, 32'b0});

    // R2 known frames
    issue(6'd0, 32'h0, 3'd3, fr); @(negedge clk);
    chk("R2 frame index 0", fr, 48'h400000000095);
    issue(6'd8, 32'h1AA, 3'd3, fr); @(negedge clk);
    chk("R2 frame index 8", fr, 48'h48000001AA87);
    issue(6'd17, 32'h0, 3'd3, fr); @(negedge clk);
    chk("R2 frame index 17", fr, 48'h510000000055);

    // sweep over every response code
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 3; k++)
        do_cmd(6'(c * 7 + k * 19 + 1), 32'h9E3779B9 * (c * 3 + k + 1), 3'(c), 0, 0, 0, k * 20);

    // R7 boundary: 63 idle samples still in time
    do_cmd(6'd13, 32'hCAFE0001, 3'd4, 0, 0, 0, 63);
    keep = rsp0;
    issue(6'd14, 32'hCAFE0002, 3'd4, fr);
    repeat (66) @(negedge clk);
    chk("R7 timeout flags", {stat2[6], stat1[0], stat2[14]}, 3'b100);
    chk("R7 rsp0 kept", rsp0, keep);

    // error injection per class
    do_cmd(6'd17, 32'h00000200, 3'd4, 1, 0, 0, 2);
    do_cmd(6'd41, 32'h0FF00000, 3'd7, 1, 0, 0, 2);
    do_cmd(6'd2,  32'h12340000, 3'd6, 1, 0, 0, 2);
    do_cmd(6'd9,  32'h00AA0000, 3'd0, 0, 1, 0, 1);
    do_cmd(6'd9,  32'h00AA0000, 3'd6, 0, 1, 0, 1);
    do_cmd(6'd55, 32'h0000BEEF, 3'd4, 0, 0, 1, 3);
    do_cmd(6'd55, 32'h0000BEEF, 3'd5, 0, 0, 1, 3);
    do_cmd(6'd55, 32'h0000BEEF, 3'd7, 0, 0, 1, 3);
    do_cmd(6'd10, 32'h0000BEE0, 3'd4, 0, 0, 0, 3);

    // R11 busy hold, with a command pending (R3 back-pressure)
    dat0_i = 1'b0;
    issue(6'd7, 32'h00001230, 3'd5, fr);
    card({88'b0, {2'b00, 6'd7, 32'h00001230}, bcrc({80'b0, 2'b00, 6'd7, 32'h00001230}, 40), 1'b1}, 48, 0);
    repeat (5) @(negedge clk);
    chk("R11 held while dat0 low", {stat2[14], stat1[0]}, 2'b10);
    cmd_word = {1'b0, 4'h5, 3'd3, 2'b00, 6'd9};
    cmd_arg = 32'h0;
    cmd_valid = 1'b1;
    @(negedge clk);
    chk("R3 pending not started", {cmd_ready, cmd_oe}, 2'b00);
    dat0_i = 1'b1;
    @(negedge clk);
    chk("R11 done after release", {stat1[0], stat2[14], cmd_ready}, 3'b101);
    chk("R11 rsp0", rsp0, 32'h00001230);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3 pending started", {cmd_oe, cmd_o, stat1[0]}, 3'b100);
    repeat (48) @(negedge clk);
    chk("R4 pending completes", {stat1[0], stat2[14]}, 2'b10);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule